// File: doc/BRIEF.md
# CAN Fault Confinement Error Counters

This block holds the transmit and receive error counters of a CAN controller and derives from them the node's fault confinement state: error active, error passive or bus off. The protocol engine feeds it single-cycle event pulses: add eight to either counter, add one to the receive counter, subtract one from either counter, and a receive-success pulse. While the node is bus off, the block also watches a strobed sampled-bit input so that it can count idle sequences.

Recovery from bus off does not use a separate counter. The transmit counter is chained behind a small internal counter of consecutive recessive bits. Each group of eleven recessive bits advances the transmit counter by one. When the count reaches 128, the node is error active again with both counters cleared. A receive-success event on a receive counter above 127 loads 119 instead of decrementing. The host may overwrite either counter only while freeze mode is asserted. All outputs are registered and change on the clock edge that samples the causing event.

Top module: `canfc_top`

## Requirements
- R1: After reset both counters read 0, the state code is 00 (error active), and stateChange and busOffIrq are low.
- R2: Outside bus off, incTx8 adds 8 to the transmit counter and decTx subtracts 1. decTx at 0 leaves it at 0. If incTx8 and decTx arrive in the same cycle, the counter gains 8.
- R3: Outside bus off, incRx8 adds 8 to the receive counter and incRx1 adds 1. When both arrive together, incRx8 wins. Increments saturate at 255. decRx subtracts 1, with no change at 0. Any increment beats a decrement or success.
- R4: Outside bus off, rxSuccess loads 119 into a receive counter that is above 127. Otherwise it acts as a decrement.
- R5: From error active (00), the state becomes error passive (01) in the same cycle that either counter's new value is 128 or more.
- R6: From error passive, the state returns to 00 in the same cycle that both counters' new values are 127 or less.
- R7: An incTx8 with the transmit counter at 248 or more moves the state to bus off (10) and clears the transmit counter. It also raises busOffIrq for exactly one cycle, together with the new state.
- R8: While bus off, all error increment, decrement and success events leave both counters unchanged.
- R9: While bus off, each bitStrobe with bitRecessive high advances an internal count. The 11th consecutive recessive bit wraps that count to 0 and adds 1 to the transmit counter. A strobed dominant bit (bitRecessive low) resets the internal count and leaves the transmit counter unchanged.
- R10: While bus off, the wrap that would bring the transmit counter to 128 instead sets the state to 00 and clears both counters.
- R11: With freezeMode high, hostWrTx or hostWrRx loads hostWrData into that counter and overrides events on it. With freezeMode low, host writes have no effect.
- R12: stateChange is high for exactly the one cycle in which faultState shows a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| incTx8 | input | 1 | Transmit error event, add 8 |
| decTx | input | 1 | Transmit success, subtract 1 |
| incRx8 | input | 1 | Receive error event, add 8 |
| incRx1 | input | 1 | Receive error event, add 1 |
| decRx | input | 1 | Receive counter subtract 1 |
| rxSuccess | input | 1 | Successful reception (decrement or preset to 119) |
| bitStrobe | input | 1 | One pulse per sampled bus bit |
| bitRecessive | input | 1 | Sampled bit value, 1 = recessive |
| freezeMode | input | 1 | Enables host writes |
| hostWrTx | input | 1 | Host write strobe for the transmit counter |
| hostWrRx | input | 1 | Host write strobe for the receive counter |
| hostWrData | input | 8 | Host write value |
| txCount | output | 8 | Transmit error counter |
| rxCount | output | 8 | Receive error counter |
| faultState | output | 2 | 00 error active, 01 error passive, 10 bus off |
| stateChange | output | 1 | One-cycle pulse on any state change |
| busOffIrq | output | 1 | One-cycle pulse on entry to bus off |

## Verification
A wrong internal idle-bit count can only be seen through the transmit counter while the node is bus off. The count is too early or too late by one bit on the next wrap, which is at most eleven strobes after the fault. A wrong state register shows on faultState and stateChange at the next edge. It also shows a cycle later as counters that move, or do not move, against the bus-off rule. Saturation and preset faults show on the counter output in the cycle after the event. The bench therefore compares every output against a model on every cycle.

// File: rtl/canfc_pkg.sv
package canfc_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'b00,
    ST_PASSIVE = 2'b01,
    ST_BUSOFF  = 2'b10
  } fcState_t;

  // control -> datapath
  typedef struct packed {
    logic evtEn;     // normal error events take effect
    logic allClear;  // recovery: clear both counters
    logic txStep;    // idle sequence completed: tx + 1
  } fcStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic txOverflow;   // incTx8 would exceed counter range
    logic txAtLast;     // tx equals recovery count minus one
    logic txNextHigh;   // normal-path tx next value at or above limit
    logic rxNextHigh;   // normal-path rx next value at or above limit
  } fcFlag_t;

endpackage

// File: rtl/canfc_counters.sv
module canfc_counters
  import canfc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int ERR_STEP    = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int RX_PRESET   = 119,
  parameter int RECOVER_CNT = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             incTx8,
  input  logic             decTx,
  input  logic             incRx8,
  input  logic             incRx1,
  input  logic             decRx,
  input  logic             rxSuccess,
  input  logic             freezeMode,
  input  logic             hostWrTx,
  input  logic             hostWrRx,
  input  logic [CNT_W-1:0] hostWrData,
  input  fcStrobe_t        strb,
  output fcFlag_t          flags,
  output logic [CNT_W-1:0] txCnt,
  output logic [CNT_W-1:0] rxCnt
);

  localparam int              SumW      = CNT_W + 1;
  localparam logic [CNT_W-1:0] CntZero  = '0;
  localparam logic [CNT_W-1:0] CntMax   = '1;
  localparam logic [CNT_W-1:0] CntOne   = CNT_W'(1);
  localparam logic [CNT_W-1:0] PassLim  = CNT_W'(PASSIVE_LIM);
  localparam logic [CNT_W-1:0] PresetV  = CNT_W'(RX_PRESET);
  localparam logic [CNT_W-1:0] RecLast  = CNT_W'(RECOVER_CNT - 1);
  localparam logic [SumW-1:0]  StepBig  = SumW'(ERR_STEP);
  localparam logic [SumW-1:0]  StepOne  = SumW'(1);

  logic             wrTx, wrRx;
  logic [SumW-1:0]  txSum, rxSum8, rxSum1;
  logic [CNT_W-1:0] txDec, rxDec, rxSat8, rxSat1;
  logic [CNT_W-1:0] txNormal, rxNormal, txWouldBe, rxWouldBe;
  logic [CNT_W-1:0] txNext, rxNext;

  assign wrTx = freezeMode & hostWrTx;
  assign wrRx = freezeMode & hostWrRx;

  // transmit normal path
  always_comb begin
    txSum = {1'b0, txCnt} + StepBig;
    txDec = (txCnt == CntZero) ? CntZero : (txCnt - CntOne);
    if (incTx8)     txNormal = txSum[CNT_W-1:0];
    else if (decTx) txNormal = txDec;
    else            txNormal = txCnt;
    txWouldBe = wrTx ? hostWrData : txNormal;
  end

  // receive normal path
  always_comb begin
    rxSum8 = {1'b0, rxCnt} + StepBig;
    rxSum1 = {1'b0, rxCnt} + StepOne;
    rxSat8 = rxSum8[CNT_W] ? CntMax : rxSum8[CNT_W-1:0];
    rxSat1 = rxSum1[CNT_W] ? CntMax : rxSum1[CNT_W-1:0];
    rxDec  = (rxCnt == CntZero) ? CntZero : (rxCnt - CntOne);
    if (incRx8)         rxNormal = rxSat8;
    else if (incRx1)    rxNormal = rxSat1;
    else if (rxSuccess) rxNormal = (rxCnt >= PassLim) ? PresetV : rxDec;
    else if (decRx)     rxNormal = rxDec;
    else                rxNormal = rxCnt;
    rxWouldBe = wrRx ? hostWrData : rxNormal;
  end

  always_comb begin
    flags.txOverflow = ~wrTx & incTx8 & txSum[CNT_W];
    flags.txAtLast   = (txCnt == RecLast);
    flags.txNextHigh = (txWouldBe >= PassLim);
    flags.rxNextHigh = (rxWouldBe >= PassLim);
  end

  always_comb begin
    if (strb.allClear)      txNext = CntZero;
    else if (wrTx)          txNext = hostWrData;
    else if (strb.evtEn)    txNext = flags.txOverflow ? CntZero : txNormal;
    else if (strb.txStep)   txNext = txCnt + CntOne;
    else                    txNext = txCnt;
  end

  always_comb begin
    if (strb.allClear)      rxNext = CntZero;
    else if (wrRx)          rxNext = hostWrData;
    else if (strb.evtEn)    rxNext = rxNormal;
    else                    rxNext = rxCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCnt <= CntZero;
      rxCnt <= CntZero;
    end else begin
      txCnt <= txNext;
      rxCnt <= rxNext;
    end
  end

  // R2: decrement at zero keeps zero
  a_r2_dec_floor: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evtEn && !strb.allClear && !wrTx && !incTx8 && decTx && txCnt == CntZero)
      |=> (txCnt == CntZero));

  // R3: receive increments saturate
  a_r3_rx_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evtEn && !strb.allClear && !wrRx && (incRx8 || incRx1) && rxCnt == CntMax)
      |=> (rxCnt == CntMax));

  // R4: success above the limit presets
  a_r4_rx_preset: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evtEn && !strb.allClear && !wrRx && !incRx8 && !incRx1 && rxSuccess &&
     rxCnt >= PassLim) |=> (rxCnt == PresetV));

  // R8: receive counter frozen while bus off
  a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.evtEn && !strb.allClear && !wrRx) |=> $stable(rxCnt));

endmodule

// File: rtl/canfc_control.sv
module canfc_control
  import canfc_pkg::*;
#(
  parameter int IDLE_BITS = 11
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitStrobe,
  input  logic      bitRecessive,
  input  fcFlag_t   flags,
  output fcStrobe_t strb,
  output fcState_t  state,
  output logic      stateChange,
  output logic      busOffIrq
);

  localparam int              RecW    = $clog2(IDLE_BITS);
  localparam logic [RecW-1:0] RecLast = RecW'(IDLE_BITS - 1);
  localparam logic [RecW-1:0] RecOne  = RecW'(1);

  logic [RecW-1:0] recCnt, recNext;
  fcState_t        stateNext;
  logic            inBusOff, idleWrap, recover;

  always_comb begin
    inBusOff = (state == ST_BUSOFF);
    idleWrap = inBusOff & bitStrobe & bitRecessive & (recCnt == RecLast);
    recover  = idleWrap & flags.txAtLast;
    strb.evtEn    = ~inBusOff;
    strb.txStep   = idleWrap;
    strb.allClear = recover;
  end

  // consecutive recessive bit counter, live only while bus off
  always_comb begin
    if (!inBusOff)                   recNext = '0;
    else if (!bitStrobe)             recNext = recCnt;
    else if (!bitRecessive)          recNext = '0;
    else if (recCnt == RecLast)      recNext = '0;
    else                             recNext = recCnt + RecOne;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_ACTIVE: begin
        if (flags.txOverflow)                          stateNext = ST_BUSOFF;
        else if (flags.txNextHigh || flags.rxNextHigh) stateNext = ST_PASSIVE;
      end
      ST_PASSIVE: begin
        if (flags.txOverflow)                            stateNext = ST_BUSOFF;
        else if (!flags.txNextHigh && !flags.rxNextHigh) stateNext = ST_ACTIVE;
      end
      ST_BUSOFF: begin
        if (recover) stateNext = ST_ACTIVE;
      end
      default: stateNext = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_ACTIVE;
      recCnt      <= '0;
      stateChange <= 1'b0;
      busOffIrq   <= 1'b0;
    end else begin
      state       <= stateNext;
      recCnt      <= recNext;
      stateChange <= (stateNext != state);
      busOffIrq   <= (stateNext == ST_BUSOFF) && (state != ST_BUSOFF);
    end
  end

  // R7: interrupt accompanies bus off entry
  a_r7_irq_with_busoff: assert property (@(posedge clk) disable iff (!rstN)
    busOffIrq |-> (state == ST_BUSOFF && stateChange));

  // R9: idle bit count stays within its window
  a_r9_rec_range: assert property (@(posedge clk) disable iff (!rstN)
    recCnt <= RecLast);

  // R10: recovery lands in error active
  a_r10_recover: assert property (@(posedge clk) disable iff (!rstN)
    (inBusOff && strb.allClear) |=> (state == ST_ACTIVE && stateChange));

  // R12: change pulse only with a new state
  a_r12_change_pulse: assert property (@(posedge clk) disable iff (!rstN)
    stateChange |-> (state != $past(state)));

endmodule

// File: rtl/canfc_top.sv
module canfc_top
  import canfc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int ERR_STEP    = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int RX_PRESET   = 119,
  parameter int RECOVER_CNT = 128,
  parameter int IDLE_BITS   = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             incTx8,
  input  logic             decTx,
  input  logic             incRx8,
  input  logic             incRx1,
  input  logic             decRx,
  input  logic             rxSuccess,
  input  logic             bitStrobe,
  input  logic             bitRecessive,
  input  logic             freezeMode,
  input  logic             hostWrTx,
  input  logic             hostWrRx,
  input  logic [CNT_W-1:0] hostWrData,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic [1:0]       faultState,
  output logic             stateChange,
  output logic             busOffIrq
);

  localparam logic [CNT_W-1:0] PassLim = CNT_W'(PASSIVE_LIM);

  fcStrobe_t strb;
  fcFlag_t   flags;
  fcState_t  state;

  canfc_counters #(
    .CNT_W(CNT_W), .ERR_STEP(ERR_STEP), .PASSIVE_LIM(PASSIVE_LIM),
    .RX_PRESET(RX_PRESET), .RECOVER_CNT(RECOVER_CNT)
  ) i_counters (
    .clk(clk), .rstN(rstN),
    .incTx8(incTx8), .decTx(decTx), .incRx8(incRx8), .incRx1(incRx1),
    .decRx(decRx), .rxSuccess(rxSuccess),
    .freezeMode(freezeMode), .hostWrTx(hostWrTx), .hostWrRx(hostWrRx),
    .hostWrData(hostWrData),
    .strb(strb), .flags(flags),
    .txCnt(txCount), .rxCnt(rxCount)
  );

  canfc_control #(.IDLE_BITS(IDLE_BITS)) i_control (
    .clk(clk), .rstN(rstN),
    .bitStrobe(bitStrobe), .bitRecessive(bitRecessive),
    .flags(flags), .strb(strb), .state(state),
    .stateChange(stateChange), .busOffIrq(busOffIrq)
  );

  assign faultState = state;

  // R5: error active implies both counters below the limit
  a_r5_active_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE) |-> (txCount < PassLim && rxCount < PassLim));

  // R6: error passive implies at least one counter at the limit
  a_r6_passive_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PASSIVE) |-> (txCount >= PassLim || rxCount >= PassLim));

endmodule

// File: tb/test_canfc_top.sv
module test_canfc_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN, incTx8, decTx, incRx8, incRx1, decRx, rxSuccess;
  logic       bitStrobe, bitRecessive, freezeMode, hostWrTx, hostWrRx;
  logic [7:0] hostWrData, txCount, rxCount;
  logic [1:0] faultState;
  logic       stateChange, busOffIrq;

  canfc_top i_canfc_top (
    .clk(clk), .rstN(rstN), .incTx8(incTx8), .decTx(decTx), .incRx8(incRx8),
    .incRx1(incRx1), .decRx(decRx), .rxSuccess(rxSuccess), .bitStrobe(bitStrobe),
    .bitRecessive(bitRecessive), .freezeMode(freezeMode), .hostWrTx(hostWrTx),
    .hostWrRx(hostWrRx), .hostWrData(hostWrData), .txCount(txCount),
    .rxCount(rxCount), .faultState(faultState), .stateChange(stateChange),
    .busOffIrq(busOffIrq)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int mTx, mRx, mSt, mRec;
  bit mChg, mIrq;

  task automatic clearIn();
    incTx8 = 0; decTx = 0; incRx8 = 0; incRx1 = 0; decRx = 0; rxSuccess = 0;
    bitStrobe = 0; bitRecessive = 0; freezeMode = 0; hostWrTx = 0; hostWrRx = 0;
    hostWrData = 8'h00;
  endtask

  // reference model of one clock edge, built from the requirements
  task automatic modelStep();
    int nTx = mTx, nRx = mRx, nSt = mSt, nRec = mRec;
    bit wrT = freezeMode && hostWrTx;
    bit wrR = freezeMode && hostWrRx;
    bit step = 0;
    mIrq = 0;
    if (mSt != 2) begin
      if (wrT) nTx = hostWrData;
      else if (incTx8) begin
        if (mTx + 8 > 255) begin nTx = 0; nSt = 2; nRec = 0; mIrq = 1; end
        else nTx = mTx + 8;
      end else if (decTx && mTx > 0) nTx = mTx - 1;
      if (wrR) nRx = hostWrData;
      else if (incRx8) nRx = (mRx + 8 > 255) ? 255 : mRx + 8;
      else if (incRx1) nRx = (mRx + 1 > 255) ? 255 : mRx + 1;
      else if (rxSuccess) nRx = (mRx > 127) ? 119 : ((mRx > 0) ? mRx - 1 : 0);
      else if (decRx && mRx > 0) nRx = mRx - 1;
      if (nSt != 2) begin
        if (mSt == 0 && (nTx >= 128 || nRx >= 128)) nSt = 1;
        else if (mSt == 1 && nTx <= 127 && nRx <= 127) nSt = 0;
      end
    end else begin
      if (bitStrobe) begin
        if (!bitRecessive) nRec = 0;
        else if (mRec == 10) begin nRec = 0; step = 1; end
        else nRec = mRec + 1;
      end
      if (step && mTx == 127) begin
        nTx = 0; nRx = 0; nSt = 0;
      end else begin
        if (wrT) nTx = hostWrData;
        else if (step) nTx = (mTx + 1) % 256;
        if (wrR) nRx = hostWrData;
      end
    end
    mChg = (nSt != mSt);
    mTx = nTx; mRx = nRx; mSt = nSt; mRec = nRec;
  endtask

  task automatic compare(string tag);
    checks++;
    if (txCount !== mTx[7:0] || rxCount !== mRx[7:0] || faultState !== mSt[1:0] ||
        stateChange !== mChg || busOffIrq !== mIrq) begin
      failures++;
      $display("FAIL %s actual tx=%0d rx=%0d st=%0d chg=%0b irq=%0b expected tx=%0d rx=%0d st=%0d chg=%0b irq=%0b",
               tag, txCount, rxCount, faultState, stateChange, busOffIrq,
               mTx, mRx, mSt, mChg, mIrq);
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    modelStep();
    @(posedge clk); #2;
    compare(tag);
    @(negedge clk);
    clearIn();
  endtask

  task automatic hostWrite(bit toTx, int val, string tag);
    freezeMode = 1; hostWrData = val[7:0];
    if (toTx) hostWrTx = 1; else hostWrRx = 1;
    tick(tag);
  endtask

  task automatic idleBits(int n, string tag);
    for (int i = 0; i < n; i++) begin
      bitStrobe = 1; bitRecessive = 1; tick(tag);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    clearIn();
    rstN = 0;
    mTx = 0; mRx = 0; mSt = 0; mRec = 0; mChg = 0; mIrq = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    checks++;
    if (txCount !== 0 || rxCount !== 0 || faultState !== 0 || stateChange !== 0 || busOffIrq !== 0) begin
      failures++;
      $display("FAIL R1 actual tx=%0d rx=%0d st=%0d expected 0 0 0", txCount, rxCount, faultState);
    end
    @(negedge clk);

    // R2 transmit arithmetic
    repeat (3) begin incTx8 = 1; tick("R2"); end
    incTx8 = 1; decTx = 1; tick("R2");
    chk("R2 inc over dec", txCount, 32);
    decTx = 1; tick("R2");
    chk("R2 dec", txCount, 31);

    // R3 receive arithmetic
    decRx = 1; tick("R3");
    chk("R3 dec at zero", rxCount, 0);
    incRx1 = 1; tick("R3");
    incRx8 = 1; tick("R3");
    incRx8 = 1; incRx1 = 1; decRx = 1; tick("R3");
    chk("R3 inc8 wins", rxCount, 17);

    // R11 freeze write, R5 passive entry, R12 pulse
    hostWrite(1, 127, "R11");
    chk("R11 freeze write", txCount, 127);
    incTx8 = 1; tick("R5");
    chk("R5 passive", faultState, 1);
    chk("R12 pulse on passive", stateChange, 1);
    tick("R12");
    chk("R12 pulse one cycle", stateChange, 0);
    hostWrTx = 1; hostWrData = 8'd5; tick("R11");
    chk("R11 write without freeze ignored", txCount, 135);

    // R4 preset
    hostWrite(0, 200, "R11");
    rxSuccess = 1; tick("R4");
    chk("R4 preset", rxCount, 119);
    rxSuccess = 1; tick("R4");
    chk("R4 success as decrement", rxCount, 118);

    // R6 back to active
    hostWrite(1, 128, "R11");
    decTx = 1; tick("R6");
    chk("R6 active", faultState, 0);

    // R3 saturation
    hostWrite(0, 250, "R5");
    incRx8 = 1; tick("R3");
    chk("R3 saturate", rxCount, 255);
    incRx1 = 1; tick("R3");

    // R7 bus off entry
    hostWrite(1, 250, "R11");
    incTx8 = 1; tick("R7");
    chk("R7 state", faultState, 2);
    chk("R7 tx cleared", txCount, 0);
    chk("R7 irq", busOffIrq, 1);
    tick("R7");
    chk("R7 irq one cycle", busOffIrq, 0);

    // R8 events ignored
    incTx8 = 1; incRx8 = 1; decRx = 1; rxSuccess = 1; tick("R8");
    chk("R8 tx hold", txCount, 0);
    chk("R8 rx hold", rxCount, 255);

    // R9 idle counting
    idleBits(10, "R9");
    bitStrobe = 1; bitRecessive = 0; tick("R9");
    idleBits(10, "R9");
    chk("R9 dominant restarts", txCount, 0);
    idleBits(1, "R9");
    chk("R9 wrap", txCount, 1);

    // R10 recovery
    hostWrite(1, 126, "R11");
    idleBits(11, "R10");
    chk("R10 pre", txCount, 127);
    idleBits(11, "R10");
    chk("R10 state", faultState, 0);
    chk("R10 tx", txCount, 0);
    chk("R10 rx", rxCount, 0);
    chk("R12 pulse on recovery", stateChange, 1);

    // constrained random
    for (int c = 0; c < 20000; c++) begin
      incTx8 = ($urandom % 100) < 30;
      decTx = ($urandom % 100) < 30;
      incRx8 = ($urandom % 100) < 10;
      incRx1 = ($urandom % 100) < 15;
      decRx = ($urandom % 100) < 20;
      rxSuccess = ($urandom % 100) < 15;
      bitStrobe = ($urandom % 2) == 0;
      bitRecessive = ($urandom % 16) != 0;
      freezeMode = ($urandom % 40) == 0;
      hostWrTx = ($urandom % 2) == 0;
      hostWrRx = ($urandom % 2) == 0;
      hostWrData = 8'($urandom);
      tick("RND");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule